// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the control step a processor core takes when it enters an exception or returns from one. On entry it receives a set of pending exception requests, the live status word and the program counter of the current instruction. It selects the single exception to take, then produces four things: the status word for the handler, the copy of the old status word to store in the target mode's bank, the link value and the vector address to fetch from. On return it takes the banked status word and the link value, rebuilds the status word and forms the resume address from a return offset.

All results are registered and appear one clock after the request cycle. A one-cycle valid pulse marks entry results and another marks return results. Requests are sampled in one cycle only; a request that loses arbitration or is masked is not held, and the core re-presents it if it stays pending. Saving general registers, fetch and the compressed-instruction link offsets belong to other logic.

Top module: `exc_seq`

## Requirements
- R1: While reset is held and in the cycle after it, `entryValid` and `retValid` are 0 and every data output is 0.
- R2: Request bit positions are 0 reset, 1 undefined instruction, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ. An entry gives `newPc` = vector offset (0x00, 0x04, 0x08, 0x0C, 0x10, 0x18, 0x1C in bit order) and `modeOut` = target mode (supervisor 0x13 for reset and software interrupt, undefined 0x1B, abort 0x17 for both aborts, IRQ 0x12, FIQ 0x11).
- R3: When `highVec` is 1, the entry `newPc` is 0xFFFF0000 plus the vector offset.
- R4: `linkOut` is `curPc`+4 for undefined instruction, software interrupt and prefetch abort, and `curPc`+8 for data abort, IRQ and FIQ. `curPc` is the address of the current or aborted instruction. Reset gives 0.
- R5: On entry `savedStatusOut` equals `curStatus`. `newStatus` keeps bits 31..8 of `curStatus`, has mode bits 4..0 equal to the target mode, and has bit 5 (T) cleared.
- R6: On entry `newStatus` bit 7 (I) is 1. Bit 6 (F) is 1 for reset and FIQ; for every other exception it keeps its value from `curStatus`.
- R7: A return request with no exception taken gives `retValid`. `newStatus` then equals `savedStatusIn`, `newPc` equals `linkIn` minus `retOffset`, and `modeOut` equals bits 4..0 of `savedStatusIn`.
- R8: Among simultaneous requests, the priority from highest to lowest is reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R9: An IRQ request is ignored while `curStatus` bit 7 is 1, and an FIQ request is ignored while bit 6 is 1. Ignored requests take no part in arbitration.
- R10: When an exception is taken in the same cycle as a return request, the return is ignored and only the entry result appears.
- R11: A cycle with no unmasked request and no return request raises neither valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 7 | Pending exception requests, one bit per type |
| curStatus | input | 32 | Live status word |
| curPc | input | 32 | Address of the current or aborted instruction |
| highVec | input | 1 | Selects the high vector base |
| retReq | input | 1 | Exception return request |
| retOffset | input | 4 | Amount subtracted from the link value on return |
| savedStatusIn | input | 32 | Banked status word to restore |
| linkIn | input | 32 | Banked link value for return |
| entryValid | output | 1 | Pulse: entry results valid |
| retValid | output | 1 | Pulse: return results valid |
| newStatus | output | 32 | Status word to install |
| savedStatusOut | output | 32 | Status word to bank on entry |
| linkOut | output | 32 | Link value to bank on entry |
| modeOut | output | 5 | Mode number now in force |
| newPc | output | 32 | Next fetch address |

## Verification
A wrong arbitration or masking decision shows up one clock later as the wrong mode number and the wrong vector on the same pulse. It can also show as a pulse that should not appear at all, so every taken or refused request is visible in the very next cycle. A bad mask-bit update is seen in bit 7 or 6 of the new status word on that same pulse. A bad link adjustment offsets `linkOut` by four. Because nothing is held between requests, no error can stay hidden beyond the cycle after its cause.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int NUM_EXC = 7;
  localparam int KIND_W  = 3;
  localparam int MODE_W  = 5;

  // Status word bit positions
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  typedef enum logic [KIND_W-1:0] {
    KIND_RESET = 3'd0,
    KIND_UNDEF = 3'd1,
    KIND_SWI   = 3'd2,
    KIND_PABT  = 3'd3,
    KIND_DABT  = 3'd4,
    KIND_IRQ   = 3'd5,
    KIND_FIQ   = 3'd6,
    KIND_NONE  = 3'd7
  } excKind_e;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  typedef struct packed {
    logic     doEntry;
    logic     doReturn;
    excKind_e kind;
  } seqStrobe_t;

  function automatic logic [7:0] vecOffset(excKind_e k);
    case (k)
      KIND_UNDEF: return 8'h04;
      KIND_SWI:   return 8'h08;
      KIND_PABT:  return 8'h0C;
      KIND_DABT:  return 8'h10;
      KIND_IRQ:   return 8'h18;
      KIND_FIQ:   return 8'h1C;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] targetMode(excKind_e k);
    case (k)
      KIND_UNDEF:          return MODE_UND;
      KIND_PABT, KIND_DABT: return MODE_ABT;
      KIND_IRQ:            return MODE_IRQ;
      KIND_FIQ:            return MODE_FIQ;
      default:             return MODE_SVC;
    endcase
  endfunction

  function automatic logic [3:0] linkAdjust(excKind_e k);
    case (k)
      KIND_UNDEF, KIND_SWI, KIND_PABT: return 4'd4;
      KIND_DABT, KIND_IRQ, KIND_FIQ:   return 4'd8;
      default:                         return 4'd0;
    endcase
  endfunction

  function automatic logic forcesFiqMask(excKind_e k);
    return (k == KIND_RESET) || (k == KIND_FIQ);
  endfunction

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
#(
  parameter int NUM_REQ = NUM_EXC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] excReq,
  input  logic               irqMaskBit,
  input  logic               fiqMaskBit,
  input  logic               retReq,
  output seqStrobe_t         strobe
);

  // Arbitration order, highest first
  localparam logic [KIND_W-1:0] PRIO [NUM_REQ] = '{
    KIND_RESET, KIND_DABT, KIND_FIQ, KIND_IRQ, KIND_PABT, KIND_UNDEF, KIND_SWI
  };

  logic [NUM_REQ-1:0] liveReq;
  excKind_e           pick;

  always_comb begin
    liveReq = excReq;
    liveReq[KIND_IRQ] = excReq[KIND_IRQ] & ~irqMaskBit;
    liveReq[KIND_FIQ] = excReq[KIND_FIQ] & ~fiqMaskBit;
  end

  // Scan lowest priority first; a higher one overrides
  always_comb begin
    pick = KIND_NONE;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (liveReq[PRIO[i]]) pick = excKind_e'(PRIO[i]);
    end
  end

  always_comb begin
    strobe.kind     = pick;
    strobe.doEntry  = (pick != KIND_NONE);
    strobe.doReturn = retReq && (pick == KIND_NONE);
  end

  // R9: a lone IRQ under mask never starts an entry
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (excReq == (NUM_REQ'(1) << KIND_IRQ) && irqMaskBit) |-> !strobe.doEntry);

  // R9: a lone FIQ under mask never starts an entry
  assert_fiq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (excReq == (NUM_REQ'(1) << KIND_FIQ) && fiqMaskBit) |-> !strobe.doEntry);

  // R8: a reset request always wins
  assert_reset_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    excReq[KIND_RESET] |-> (strobe.kind == KIND_RESET));

  // R10: a return is never started alongside an entry
  assert_ret_yields_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doEntry |-> !strobe.doReturn);

endmodule

// File: rtl/exc_seq_dp.sv
module exc_seq_dp
  import exc_seq_pkg::*;
#(
  parameter int                WORD_W     = 32,
  parameter int                OFF_W      = 4,
  parameter logic [WORD_W-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [WORD_W-1:0] curStatus,
  input  logic [WORD_W-1:0] curPc,
  input  logic              highVec,
  input  logic [OFF_W-1:0]  retOffset,
  input  logic [WORD_W-1:0] savedStatusIn,
  input  logic [WORD_W-1:0] linkIn,
  output logic              entryValid,
  output logic              retValid,
  output logic [WORD_W-1:0] newStatus,
  output logic [WORD_W-1:0] savedStatusOut,
  output logic [WORD_W-1:0] linkOut,
  output logic [MODE_W-1:0] modeOut,
  output logic [WORD_W-1:0] newPc
);

  localparam int HI_W = WORD_W - BIT_I - 1;

  logic [WORD_W-1:0] vecAddr;
  logic [WORD_W-1:0] entryStatus;
  logic [WORD_W-1:0] entryLink;
  logic [WORD_W-1:0] resumePc;
  logic [MODE_W-1:0] entryMode;

  always_comb begin
    entryMode = targetMode(strobe.kind);
    vecAddr   = WORD_W'(vecOffset(strobe.kind));
    if (highVec) vecAddr = HIVEC_BASE + vecAddr;
    entryLink = (strobe.kind == KIND_RESET) ? '0
              : curPc + WORD_W'(linkAdjust(strobe.kind));
    entryStatus = {curStatus[WORD_W-1:BIT_I+1],
                   1'b1,
                   curStatus[BIT_F] | forcesFiqMask(strobe.kind),
                   1'b0,
                   entryMode};
    resumePc = linkIn - WORD_W'(retOffset);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryValid     <= 1'b0;
      retValid       <= 1'b0;
      newStatus      <= '0;
      savedStatusOut <= '0;
      linkOut        <= '0;
      modeOut        <= '0;
      newPc          <= '0;
    end else begin
      entryValid <= strobe.doEntry;
      retValid   <= strobe.doReturn;
      if (strobe.doEntry) begin
        newStatus      <= entryStatus;
        savedStatusOut <= curStatus;
        linkOut        <= entryLink;
        modeOut        <= entryMode;
        newPc          <= vecAddr;
      end else if (strobe.doReturn) begin
        newStatus <= savedStatusIn;
        modeOut   <= savedStatusIn[MODE_W-1:0];
        newPc     <= resumePc;
      end
    end
  end

  // R6: handler always starts with IRQs masked and outside compressed state
  assert_entry_masks_R6: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (newStatus[BIT_I] && !newStatus[BIT_T]));

  // R5: banked copy is the status word seen in the request cycle
  assert_saved_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (savedStatusOut == $past(curStatus)));

  // R5: upper status bits pass through entry untouched
  assert_upper_keep_R5: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (newStatus[WORD_W-1:BIT_I+1] == $past(curStatus[WORD_W-1:BIT_I+1])));

  // R2: mode field of the new status matches the reported mode
  assert_mode_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (newStatus[MODE_W-1:0] == modeOut));

  // R3: high vectors place the target in the top page
  assert_hivec_R3: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && $past(highVec)) |-> (newPc[WORD_W-1:16] == HIVEC_BASE[WORD_W-1:16]));

  // R7: return installs the banked status word
  assert_ret_restore_R7: assert property (@(posedge clk) disable iff (!rstN)
    retValid |-> (newStatus == $past(savedStatusIn)));

  // R11: valid pulses never overlap
  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({entryValid, retValid}));

  if (HI_W < 1) begin : g_bad_width
    initial $error("WORD_W too small for status layout");
  end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_EXC-1:0] excReq,
  input  logic [WORD_W-1:0] curStatus,
  input  logic [WORD_W-1:0] curPc,
  input  logic              highVec,
  input  logic              retReq,
  input  logic [OFF_W-1:0]  retOffset,
  input  logic [WORD_W-1:0] savedStatusIn,
  input  logic [WORD_W-1:0] linkIn,
  output logic              entryValid,
  output logic              retValid,
  output logic [WORD_W-1:0] newStatus,
  output logic [WORD_W-1:0] savedStatusOut,
  output logic [WORD_W-1:0] linkOut,
  output logic [MODE_W-1:0] modeOut,
  output logic [WORD_W-1:0] newPc
);

  seqStrobe_t strobe;

  exc_seq_ctrl #(.NUM_REQ(NUM_EXC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .excReq     (excReq),
    .irqMaskBit (curStatus[BIT_I]),
    .fiqMaskBit (curStatus[BIT_F]),
    .retReq     (retReq),
    .strobe     (strobe)
  );

  exc_seq_dp #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .curStatus      (curStatus),
    .curPc          (curPc),
    .highVec        (highVec),
    .retOffset      (retOffset),
    .savedStatusIn  (savedStatusIn),
    .linkIn         (linkIn),
    .entryValid     (entryValid),
    .retValid       (retValid),
    .newStatus      (newStatus),
    .savedStatusOut (savedStatusOut),
    .linkOut        (linkOut),
    .modeOut        (modeOut),
    .newPc          (newPc)
  );

endmodule

// File: tb/exc_seq_tb.sv
module exc_seq_tb;

  typedef struct {
    logic        ent;
    logic        ret;
    logic [31:0] st;
    logic [31:0] sav;
    logic [31:0] lnk;
    logic [4:0]  mode;
    logic [31:0] pc;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  excReq = '0;
  logic [31:0] curStatus = '0, curPc = '0, savedStatusIn = '0, linkIn = '0;
  logic        highVec = 1'b0, retReq = 1'b0;
  logic [3:0]  retOffset = '0;
  logic        entryValid, retValid;
  logic [31:0] newStatus, savedStatusOut, linkOut, newPc;
  logic [4:0]  modeOut;

  int compared = 0;
  int mismatched = 0;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  exc_seq u_dut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .curStatus(curStatus),
    .curPc(curPc), .highVec(highVec), .retReq(retReq), .retOffset(retOffset),
    .savedStatusIn(savedStatusIn), .linkIn(linkIn), .entryValid(entryValid),
    .retValid(retValid), .newStatus(newStatus), .savedStatusOut(savedStatusOut),
    .linkOut(linkOut), .modeOut(modeOut), .newPc(newPc)
  );

  // Reference model written from the requirements
  function automatic expItem_t model(logic [6:0] req, logic [31:0] st,
      logic [31:0] pc, logic hv, logic rr, logic [3:0] off,
      logic [31:0] sv, logic [31:0] lk, string tag);
    int order [7] = '{0, 4, 6, 5, 3, 1, 2};
    logic [31:0] offs [7] = '{32'h00, 32'h04, 32'h08, 32'h0C, 32'h10, 32'h18, 32'h1C};
    logic [4:0]  modes [7] = '{5'h13, 5'h1B, 5'h13, 5'h17, 5'h17, 5'h12, 5'h11};
    logic [31:0] adj [7] = '{32'd0, 32'd4, 32'd4, 32'd4, 32'd8, 32'd8, 32'd8};
    logic [6:0] live;
    int k;
    expItem_t e;
    live = req;
    if (st[7]) live[5] = 1'b0;
    if (st[6]) live[6] = 1'b0;
    k = -1;
    for (int i = 6; i >= 0; i--) if (live[order[i]]) k = order[i];
    e.tag = tag; e.ent = 1'b0; e.ret = 1'b0;
    e.st = '0; e.sav = '0; e.lnk = '0; e.mode = '0; e.pc = '0;
    if (k >= 0) begin
      e.ent  = 1'b1;
      e.mode = modes[k];
      e.sav  = st;
      e.lnk  = (k == 0) ? 32'd0 : pc + adj[k];
      e.pc   = hv ? 32'hFFFF0000 + offs[k] : offs[k];
      e.st   = {st[31:8], 1'b1, st[6] | (k == 0) | (k == 6), 1'b0, modes[k]};
    end else if (rr) begin
      e.ret  = 1'b1;
      e.st   = sv;
      e.mode = sv[4:0];
      e.pc   = lk - {28'd0, off};
    end
    return e;
  endfunction

  task automatic drive(logic [6:0] req, logic [31:0] st, logic [31:0] pc,
      logic hv, logic rr, logic [3:0] off, logic [31:0] sv, logic [31:0] lk,
      string tag);
    @(negedge clk);
    excReq = req; curStatus = st; curPc = pc; highVec = hv;
    retReq = rr; retOffset = off; savedStatusIn = sv; linkIn = lk;
    expQ.push_back(model(req, st, pc, hv, rr, off, sv, lk, tag));
  endtask

  // Monitor: compare one expected item per cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      logic bad;
      e = expQ.pop_front();
      bad = (entryValid !== e.ent) || (retValid !== e.ret);
      if (e.ent) bad = bad || newStatus !== e.st || savedStatusOut !== e.sav ||
                       linkOut !== e.lnk || modeOut !== e.mode || newPc !== e.pc;
      if (e.ret) bad = bad || newStatus !== e.st || modeOut !== e.mode || newPc !== e.pc;
      compared++;
      if (bad) begin
        mismatched++;
        $display("FAIL %s: got ent=%b ret=%b st=%h sav=%h lnk=%h mode=%h pc=%h exp ent=%b ret=%b st=%h sav=%h lnk=%h mode=%h pc=%h",
          e.tag, entryValid, retValid, newStatus, savedStatusOut, linkOut, modeOut, newPc,
          e.ent, e.ret, e.st, e.sav, e.lnk, e.mode, e.pc);
      end
    end
  end

  initial begin : watchdog
    #400000;
    mismatched++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic checkIdleOutputs(string tag);
    compared++;
    if (entryValid !== 1'b0 || retValid !== 1'b0 || newStatus !== '0 ||
        savedStatusOut !== '0 || linkOut !== '0 || modeOut !== '0 || newPc !== '0) begin
      mismatched++;
      $display("FAIL %s: got ent=%b ret=%b st=%h pc=%h exp all zero",
        tag, entryValid, retValid, newStatus, newPc);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 checkIdleOutputs("R1 in reset");
    @(negedge clk) rstN = 1'b1;
    @(posedge clk) #1 checkIdleOutputs("R1 after reset");

    // R2/R4/R5/R6: each type alone, flags and T set, F clear
    for (int k = 0; k < 7; k++)
      drive(7'(1) << k, 32'hF000_0030, 32'h0000_8000 + 32'(k * 16), 1'b0, 1'b0, 4'd0,
            '0, '0, $sformatf("R2 R4 R5 type %0d", k));
    // R3: high vectors, F already set elsewhere preserved (R6)
    for (int k = 0; k < 5; k++)
      drive(7'(1) << k, 32'h5000_0050, 32'h0001_0000, 1'b1, 1'b0, 4'd0,
            '0, '0, $sformatf("R3 R6 type %0d", k));
    drive(7'b0100000, 32'h0000_0010, 32'h20, 1'b1, 1'b0, 4'd0, '0, '0, "R3 irq");
    drive(7'b1000000, 32'h0000_0010, 32'h24, 1'b1, 1'b0, 4'd0, '0, '0, "R3 fiq");
    // R8: priority pairs
    drive(7'b1111111, 32'h10, 32'h100, 1'b0, 1'b0, 4'd0, '0, '0, "R8 all");
    drive(7'b1010000, 32'h10, 32'h104, 1'b0, 1'b0, 4'd0, '0, '0, "R8 dabt over fiq");
    drive(7'b1100000, 32'h10, 32'h108, 1'b0, 1'b0, 4'd0, '0, '0, "R8 fiq over irq");
    drive(7'b0101000, 32'h10, 32'h10C, 1'b0, 1'b0, 4'd0, '0, '0, "R8 irq over pabt");
    drive(7'b0001010, 32'h10, 32'h110, 1'b0, 1'b0, 4'd0, '0, '0, "R8 pabt over undef");
    drive(7'b0000110, 32'h10, 32'h114, 1'b0, 1'b0, 4'd0, '0, '0, "R8 undef over swi");
    // R9: masking
    drive(7'b0100000, 32'h90, 32'h200, 1'b0, 1'b0, 4'd0, '0, '0, "R9 irq masked");
    drive(7'b1000000, 32'h50, 32'h204, 1'b0, 1'b0, 4'd0, '0, '0, "R9 fiq masked");
    drive(7'b1100000, 32'h50, 32'h208, 1'b0, 1'b0, 4'd0, '0, '0, "R9 masked fiq gives irq");
    drive(7'b1101000, 32'h90, 32'h20C, 1'b0, 1'b0, 4'd0, '0, '0, "R9 masked irq gives fiq");
    drive(7'b0101000, 32'h90, 32'h210, 1'b0, 1'b0, 4'd0, '0, '0, "R9 masked irq gives pabt");
    // R11: idle
    drive(7'b0, 32'h10, 32'h300, 1'b0, 1'b0, 4'd0, '0, '0, "R11 idle");
    // R7: returns
    drive(7'b0, 32'h92, 32'h0, 1'b0, 1'b1, 4'd4, 32'hA000_0010, 32'h0000_8124, "R7 ret off4");
    drive(7'b0, 32'hD1, 32'h0, 1'b0, 1'b1, 4'd8, 32'h6000_0033, 32'h0000_9008, "R7 ret off8");
    drive(7'b0, 32'h97, 32'h0, 1'b0, 1'b1, 4'd0, 32'h0000_0050, 32'h0000_0004, "R7 ret off0");
    // R10: return alongside exception
    drive(7'b0000100, 32'h13, 32'h400, 1'b0, 1'b1, 4'd4, 32'h10, 32'h1000, "R10 swi beats ret");
    drive(7'b0100000, 32'h92, 32'h404, 1'b0, 1'b1, 4'd4, 32'h10, 32'h1000, "R10 masked irq lets ret");
    drive(7'b0, 32'h10, 32'h0, 1'b0, 1'b0, 4'd0, '0, '0, "R11 idle end");
    @(negedge clk);
    excReq = '0; retReq = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule